// File: doc/BRIEF.md
# Pulse-Width Bit Symbol Engine

This engine sits on one open-drain, active-low wire and carries single bit symbols whose meaning lies only in how long the wire stays low. A client asks for one symbol at a time through a request/accept handshake. For the three transmit kinds (SYNC, ZERO, ONE) the engine pulls the wire low for a set number of time units, then lets it go. For a read slot it acts as the master of a slave reply. It pulls the wire low for the sync time, lets it go, and measures how long the slave keeps the wire low. It then reports that length as a received symbol, or as a timeout or framing error.

Time is counted in units marked by a one-cycle `tick` strobe from outside. The tick period must be at least three clock cycles, so that a release always passes the input synchronizer before the next unit boundary. The wire input goes through a synchronizer of two flops before the engine acts on it. After every symbol the engine waits for a unit boundary during which it sees the wire released, and only then accepts the next request. Sequencing symbols into frames is left to the client.

Top module: `pwsym_engine`

## Requirements
- R1: During and after reset `drive_low` is 0, `req_ready` is 1 and `rx_valid` is 0.
- R2: A request with `req_kind` = 0 (SYNC) holds `drive_low` high for exactly 1 tick. The release happens at the clock edge that consumes the last tick.
- R3: `req_kind` = 1 (ZERO) holds `drive_low` high for exactly 3 ticks, and `req_kind` = 2 (ONE) holds it for exactly 6 ticks.
- R4: `req_ready` is high only while the engine is idle and never while `drive_low` is high. A request is taken at the edge where `req_valid` and `req_ready` are both high, and `drive_low` rises at that same edge.
- R5: `req_kind` = 3 (read slot) holds `drive_low` high for exactly 1 tick, then releases the wire.
- R6: In a read slot, the low length L is the number of ticks counted from acceptance until the synchronized wire is seen high. When the wire is seen high, `rx_valid` pulses for one cycle. `rx_sym` is 1 (ZERO) for L from 2 to 4 and 2 (ONE) for L from 5 to 8, with both error flags low.
- R7: If L is below 2, the slave did not hold the wire past the sync time. `rx_valid` pulses with `rx_err_timeout` = 1, `rx_sym` = 0 (SYNC) and `rx_err_frame` = 0.
- R8: If the wire is still low when the ninth tick is counted, `rx_valid` pulses right away with `rx_err_frame` = 1 and `rx_err_timeout` = 0. The engine then waits for the wire to be released.
- R9: After any symbol, `req_ready` rises only at the edge after a tick during which the synchronized wire is high. While another party holds the wire low, `req_ready` stays 0.
- R10: When the synchronized release and a tick fall in the same cycle, the release wins. L is the count before that tick, so no symbol change and no framing error comes from that tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle time-unit strobe |
| req_valid | input | 1 | Symbol request present |
| req_kind | input | 2 | 0 SYNC, 1 ZERO, 2 ONE, 3 read slot |
| req_ready | output | 1 | Engine idle, request accepted when valid |
| bus_in | input | 1 | Wire level (asynchronous, low = asserted) |
| drive_low | output | 1 | Pull the wire low when 1 |
| rx_valid | output | 1 | One-cycle strobe: read slot result |
| rx_sym | output | 2 | Received symbol: 0 SYNC, 1 ZERO, 2 ONE |
| rx_err_timeout | output | 1 | Slave did not hold past sync, with rx_valid |
| rx_err_frame | output | 1 | Low time exceeded the limit, with rx_valid |

## Verification
Two of the engine's functions can meet in one cycle: seeing the slave's release and counting a tick. The eight-unit limit can also land on that same tick. The bench models the slave releasing a set number of ticks into the slot and delays the release by 0 to 5 clocks after that tick. With a 8-clock tick period, a 5-clock delay makes the synchronized release arrive exactly on the next tick. The expected length stays the slave's tick count for every delay, so a design that lets the tick win reports one unit too many. At length 8 it reports a framing error instead of ONE.

// File: rtl/pwsym_pkg.sv
package pwsym_pkg;

  typedef enum logic [1:0] {
    SYM_SYNC = 2'd0,
    SYM_ZERO = 2'd1,
    SYM_ONE  = 2'd2,
    SYM_READ = 2'd3
  } sym_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TXLOW,
    ST_RXMST,
    ST_RXHOLD,
    ST_DRAIN,
    ST_GAP
  } pw_state_e;

  // low duration in ticks for a transmit symbol
  function automatic int unsigned units_of(sym_e kind, int unsigned u_sync,
                                           int unsigned u_zero, int unsigned u_one);
    int unsigned r;
    case (kind)
      SYM_SYNC: r = u_sync;
      SYM_ZERO: r = u_zero;
      default:  r = u_one;
    endcase
    return r;
  endfunction

  // symbol from a measured low length
  function automatic sym_e classify(int unsigned len, int unsigned zmin,
                                    int unsigned zmax);
    sym_e r;
    if (len < zmin)       r = SYM_SYNC;
    else if (len <= zmax) r = SYM_ZERO;
    else                  r = SYM_ONE;
    return r;
  endfunction

endpackage

// File: rtl/pwsym_insync.sv
module pwsym_insync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic d_sync
);
  logic [STAGES-1:0] sh_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sh_q[0] <= 1'b1;
          else        sh_q[0] <= d_async;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sh_q[i] <= 1'b1;
          else        sh_q[i] <= sh_q[i-1];
        end
      end
    end
  endgenerate

  assign d_sync = sh_q[STAGES-1];
endmodule

// File: rtl/pwsym_unitcnt.sv
module pwsym_unitcnt #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  output logic [CW-1:0] cnt
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cnt_q <= '0;
    else if (clr)                  cnt_q <= '0;
    else if (inc && !(&cnt_q))     cnt_q <= cnt_q + CW'(1);
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/pwsym_ctrl.sv
module pwsym_ctrl
  import pwsym_pkg::*;
#(
  parameter int U_SYNC   = 1,
  parameter int U_ZERO   = 3,
  parameter int U_ONE    = 6,
  parameter int ZERO_MIN = 2,
  parameter int ZERO_MAX = 4,
  parameter int MAX_LOW  = 8,
  parameter int CW       = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          bus_s,
  input  logic          req_valid,
  input  logic [1:0]    req_kind,
  input  logic [CW-1:0] cnt,
  output logic          cnt_clr,
  output logic          cnt_inc,
  output logic          req_ready,
  output logic          drive_low,
  output logic          rx_valid,
  output logic [1:0]    rx_sym,
  output logic          rx_err_timeout,
  output logic          rx_err_frame,
  output logic          ev_accept
);
  pw_state_e     st_q, st_d;
  logic          drv_q, drv_d;
  logic [CW-1:0] units_q, units_d;
  logic          rxv_q, rxv_d;
  sym_e          rxs_q, rxs_d;
  logic          rto_q, rto_d;
  logic          rfe_q, rfe_d;
  sym_e          kind;
  logic [CW-1:0] cnt_nx;

  assign kind   = sym_e'(req_kind);
  assign cnt_nx = cnt + CW'(1);

  always_comb begin
    st_d      = st_q;
    drv_d     = drv_q;
    units_d   = units_q;
    rxv_d     = 1'b0;
    rxs_d     = rxs_q;
    rto_d     = 1'b0;
    rfe_d     = 1'b0;
    cnt_clr   = 1'b0;
    cnt_inc   = 1'b0;
    ev_accept = (st_q == ST_IDLE) && req_valid;
    unique case (st_q)
      ST_IDLE: begin
        if (req_valid) begin
          cnt_clr = 1'b1;
          drv_d   = 1'b1;
          if (kind == SYM_READ) begin
            st_d = ST_RXMST;
          end else begin
            st_d    = ST_TXLOW;
            units_d = CW'(units_of(kind, U_SYNC, U_ZERO, U_ONE));
          end
        end
      end
      ST_TXLOW: begin
        if (tick) begin
          cnt_inc = 1'b1;
          if (cnt_nx == units_q) begin
            drv_d   = 1'b0;
            st_d    = ST_GAP;
            cnt_clr = 1'b1;
          end
        end
      end
      ST_RXMST: begin
        if (tick) begin
          cnt_inc = 1'b1;
          if (cnt_nx == CW'(U_SYNC)) begin
            drv_d = 1'b0;
            st_d  = ST_RXHOLD;
          end
        end
      end
      ST_RXHOLD: begin
        // release seen first: the tick of this cycle is not counted
        if (bus_s) begin
          rxv_d   = 1'b1;
          rxs_d   = classify(32'(cnt), ZERO_MIN, ZERO_MAX);
          rto_d   = (32'(cnt) < ZERO_MIN);
          st_d    = ST_GAP;
          cnt_clr = 1'b1;
        end else if (tick) begin
          if (cnt == CW'(MAX_LOW)) begin
            rxv_d = 1'b1;
            rxs_d = SYM_ONE;
            rfe_d = 1'b1;
            st_d  = ST_DRAIN;
          end else begin
            cnt_inc = 1'b1;
          end
        end
      end
      ST_DRAIN: begin
        if (bus_s) begin
          st_d    = ST_GAP;
          cnt_clr = 1'b1;
        end
      end
      ST_GAP: begin
        if (bus_s && tick) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      drv_q   <= 1'b0;
      units_q <= '0;
      rxv_q   <= 1'b0;
      rxs_q   <= SYM_SYNC;
      rto_q   <= 1'b0;
      rfe_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      drv_q   <= drv_d;
      units_q <= units_d;
      rxv_q   <= rxv_d;
      rxs_q   <= rxs_d;
      rto_q   <= rto_d;
      rfe_q   <= rfe_d;
    end
  end

  assign req_ready      = (st_q == ST_IDLE);
  assign drive_low      = drv_q;
  assign rx_valid       = rxv_q;
  assign rx_sym         = rxs_q;
  assign rx_err_timeout = rto_q;
  assign rx_err_frame   = rfe_q;
endmodule

// File: rtl/pwsym_engine.sv
module pwsym_engine #(
  parameter int U_SYNC      = 1,
  parameter int U_ZERO      = 3,
  parameter int U_ONE       = 6,
  parameter int ZERO_MIN    = 2,
  parameter int ZERO_MAX    = 4,
  parameter int MAX_LOW     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       req_valid,
  input  logic [1:0] req_kind,
  output logic       req_ready,
  input  logic       bus_in,
  output logic       drive_low,
  output logic       rx_valid,
  output logic [1:0] rx_sym,
  output logic       rx_err_timeout,
  output logic       rx_err_frame
);
  localparam int CW = $clog2(MAX_LOW + 2);

  logic          bus_s;
  logic          ev_accept;
  logic          cnt_clr;
  logic          cnt_inc;
  logic [CW-1:0] cnt;

  pwsym_insync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (bus_in),
    .d_sync  (bus_s)
  );

  pwsym_unitcnt #(.CW(CW)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (cnt_clr),
    .inc   (cnt_inc),
    .cnt   (cnt)
  );

  pwsym_ctrl #(
    .U_SYNC   (U_SYNC),
    .U_ZERO   (U_ZERO),
    .U_ONE    (U_ONE),
    .ZERO_MIN (ZERO_MIN),
    .ZERO_MAX (ZERO_MAX),
    .MAX_LOW  (MAX_LOW),
    .CW       (CW)
  ) u_ctrl (
    .clk            (clk),
    .rst_n          (rst_n),
    .tick           (tick),
    .bus_s          (bus_s),
    .req_valid      (req_valid),
    .req_kind       (req_kind),
    .cnt            (cnt),
    .cnt_clr        (cnt_clr),
    .cnt_inc        (cnt_inc),
    .req_ready      (req_ready),
    .drive_low      (drive_low),
    .rx_valid       (rx_valid),
    .rx_sym         (rx_sym),
    .rx_err_timeout (rx_err_timeout),
    .rx_err_frame   (rx_err_frame),
    .ev_accept      (ev_accept)
  );
endmodule

// File: rtl/pwsym_chk.sv
module pwsym_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       req_ready,
  input logic       drive_low,
  input logic       rx_valid,
  input logic [1:0] rx_sym,
  input logic       rx_err_timeout,
  input logic       rx_err_frame,
  input logic       bus_s,
  input logic       ev_accept
);
  p_ready_not_driving_r4: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !drive_low);

  p_drive_on_accept_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drive_low) |-> $past(ev_accept));

  p_release_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(drive_low) |-> $past(tick));

  p_timeout_is_sync_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_err_timeout) |-> (rx_sym == 2'd0 && !rx_err_frame));

  p_err_with_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_err_frame || rx_err_timeout) |-> rx_valid);

  p_result_after_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_err_frame) |-> $past(bus_s));

  p_rx_one_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  p_gap_needs_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_ready) |-> $past(tick && bus_s));
endmodule

bind pwsym_engine pwsym_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .tick           (tick),
  .req_ready      (req_ready),
  .drive_low      (drive_low),
  .rx_valid       (rx_valid),
  .rx_sym         (rx_sym),
  .rx_err_timeout (rx_err_timeout),
  .rx_err_frame   (rx_err_frame),
  .bus_s          (bus_s),
  .ev_accept      (ev_accept)
);

// File: tb/test_pwsym_engine.sv
module test_pwsym_engine;
  localparam int TDIV = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       req_valid = 1'b0;
  logic [1:0] req_kind = 2'd0;
  logic       slv_low = 1'b0;
  logic       ext_low = 1'b0;
  logic       req_ready, drive_low, rx_valid, rx_err_timeout, rx_err_frame;
  logic [1:0] rx_sym;
  wire        bus_in = ~(drive_low | slv_low | ext_low);

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;
  int tdiv = 0;

  pwsym_engine i_pwsym_engine (
    .clk(clk), .rst_n(rst_n), .tick(tick), .req_valid(req_valid),
    .req_kind(req_kind), .req_ready(req_ready), .bus_in(bus_in),
    .drive_low(drive_low), .rx_valid(rx_valid), .rx_sym(rx_sym),
    .rx_err_timeout(rx_err_timeout), .rx_err_frame(rx_err_frame)
  );

  always #5 clk = ~clk;

  always @(negedge clk) begin
    if (tdiv == TDIV - 1) begin tdiv <= 0; tick <= 1'b1; end
    else begin tdiv <= tdiv + 1; tick <= 1'b0; end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_chk = n_chk + 1;
      n_err = n_err + 1;
      $display("FAIL watchdog: run hung, act=%0d exp<150000 cycles", cyc);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk); #1;
  endtask

  // transmit one symbol, count low ticks
  task automatic run_tx(input int kind);
    int  lowt = 0;
    int  guard = 0;
    bit  ready_bad = 0;
    bit  seen_hi_tick = 0;
    bit  gap_ok = 1;
    int  exp_u;
    exp_u = (kind == 0) ? 1 : (kind == 1) ? 3 : 6;
    req_valid = 1'b1; req_kind = 2'(kind);
    step();
    req_valid = 1'b0;
    chk(drive_low == 1'b1, "R4 drive after accept", int'(drive_low), 1);
    while (drive_low && guard < 200) begin
      if (req_ready) ready_bad = 1;
      if (tick) lowt++;
      step(); guard++;
    end
    chk(lowt == exp_u, (kind == 0) ? "R2 SYNC low ticks" : "R3 low ticks", lowt, exp_u);
    chk(!ready_bad, "R4 ready while driving", int'(ready_bad), 0);
    guard = 0;
    while (!req_ready && guard < 200) begin
      if (tick && bus_in && guard >= 2) seen_hi_tick = 1;
      step(); guard++;
    end
    if (!seen_hi_tick) gap_ok = 0;
    chk(gap_ok, "R9 gap tick before ready", int'(seen_hi_tick), 1);
  endtask

  // read slot; slave holds n ticks, then releases k clocks later
  task automatic run_rx(input int n, input int k);
    int   drvt = 0;
    int   tc = 0;
    int   rel = -1;
    int   guard = 0;
    bit   got = 0;
    int   gsym = 0;
    bit   gto = 0;
    bit   gfe = 0;
    int   esym;
    bit   eto, efe;
    string tg;
    efe  = (n > 8);
    eto  = (n < 2);
    esym = (n < 2) ? 0 : (n <= 4) ? 1 : 2;
    tg   = (k == 5) ? "R10" : "R6";
    req_valid = 1'b1; req_kind = 2'd3;
    step();
    req_valid = 1'b0;
    slv_low = (n > 0);
    while (!(got && req_ready) && guard < 400) begin
      if (drive_low && tick) drvt++;
      if (slv_low) begin
        if (rel >= 0) begin
          if (rel == 0) slv_low = 1'b0; else rel--;
        end else if (tick) begin
          tc++;
          if (tc == n) rel = k;
        end
      end
      if (rx_valid) begin
        got = 1; gsym = int'(rx_sym); gto = rx_err_timeout; gfe = rx_err_frame;
      end
      step(); guard++;
    end
    slv_low = 1'b0;
    chk(drvt == 1, "R5 master sync ticks", drvt, 1);
    chk(got, {tg, " result strobe"}, int'(got), 1);
    if (efe) begin
      chk(gfe && !gto, "R8 frame error", int'(gfe), 1);
    end else if (eto) begin
      chk(gto && !gfe && gsym == 0, "R7 timeout", int'(gto) * 10 + gsym, 10);
    end else begin
      chk(!gto && !gfe && gsym == esym, {tg, " symbol"}, gsym, esym);
    end
  endtask

  task automatic run_hold_gap();
    int  guard = 0;
    bit  bad = 0;
    req_valid = 1'b1; req_kind = 2'd0;
    step();
    req_valid = 1'b0;
    ext_low = 1'b1;
    while (drive_low && guard < 200) begin step(); guard++; end
    for (int i = 0; i < 5 * TDIV; i++) begin
      if (req_ready) bad = 1;
      step();
    end
    chk(!bad, "R9 ready held off by foreign low", int'(bad), 0);
    ext_low = 1'b0;
    guard = 0;
    while (!req_ready && guard < 200) begin step(); guard++; end
    chk(req_ready == 1'b1, "R9 ready after release", int'(req_ready), 1);
  endtask

  initial begin
    step();
    chk(drive_low == 1'b0 && req_ready == 1'b1 && rx_valid == 1'b0,
        "R1 state in reset", int'({drive_low, req_ready, rx_valid}), 3'b010);
    repeat (3) step();
    rst_n = 1'b1;
    step();
    chk(drive_low == 1'b0 && req_ready == 1'b1 && rx_valid == 1'b0,
        "R1 state after reset", int'({drive_low, req_ready, rx_valid}), 3'b010);
    for (int kd = 0; kd < 3; kd++) run_tx(kd);
    for (int n = 0; n <= 10; n++) begin
      for (int k = 0; k <= 5; k++) run_rx(n, k);
    end
    run_hold_gap();
    run_tx(2);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule